// File: doc/BRIEF.md
# Threshold-Gated Write Data Buffer

This block sits on the write data channel of an AXI4 path, between the component that produces write beats and the component that consumes them. Each accepted beat (data, byte strobes and the end-of-burst flag) is stored in a first-in first-out buffer. The output side does not offer a beat as soon as one is stored. It waits until the buffer holds at least a set number of beats, the fill mark, or until a beat flagged as the end of a burst has been stored, whichever happens first.

Once the output is opened, it stays open until the end-of-burst beat has been handed on. This lets the rest of the burst stream at one beat per cycle, even when the occupancy briefly falls below the mark. When that final beat leaves, the gate closes again and the next burst must meet the same condition. Both sides use the usual valid/ready handshake. The consumer therefore sees bursts that arrive in dense groups instead of in the producer's uneven pattern.

Top module: `wbuf_tidemark`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1.
- R2: A beat moves on either side only in a cycle where valid and ready are both 1. `s_ready` is 0 while DEPTH beats are stored. A beat offered on the output with `m_ready` low stays offered and unchanged.
- R3: With the gate closed and no end-of-burst beat stored, `m_valid` stays 0 while fewer than MARK beats are stored.
- R4: Storing a beat with `s_last` = 1 opens the output, even when fewer than MARK beats are stored.
- R5: A beat that completes the opening condition on a clock edge makes `m_valid` 1 right after that edge. Data therefore reaches the output one cycle after it is accepted.
- R6: Once opened, the output stays open (m_valid = 1 whenever the buffer is non-empty) until a beat with last = 1 is handed on. After that, the output stays closed until the condition is met again.
- R7: Data, strobe and last leave together and in the order they were accepted.
- R8: If one beat is accepted and one is handed on in the same cycle, the occupancy does not change. In steady streaming through a part-filled buffer, both sides therefore stay ready every cycle.
- R9: Reset empties the buffer and closes the gate, even in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Producer offers a beat |
| s_ready | output | 1 | Buffer can accept a beat |
| s_data | input | DATA_W | Write data of the offered beat |
| s_strb | input | DATA_W/8 | Byte strobes of the offered beat |
| s_last | input | 1 | Offered beat ends its burst |
| m_valid | output | 1 | Buffer offers a beat to the consumer |
| m_ready | input | 1 | Consumer takes the offered beat |
| m_data | output | DATA_W | Write data of the head beat |
| m_strb | output | DATA_W/8 | Byte strobes of the head beat |
| m_last | output | 1 | Head beat ends its burst |

## Verification
The bench uses DATA_W = 32, DEPTH = 8 and MARK = 4. With a mark below the depth, the bench can show three cases: a held-back partial fill, release on reaching the mark, and release by an end-of-burst beat while under the mark. With a depth of twice the mark, a full buffer can be built up behind a stalled consumer, and the bench then checks the back-pressure and a steady push-and-pop stream at an occupancy of seven. A scoreboard compares every output beat with the accepted sequence.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Fill-mark test used by the gate; kept as a function so the rule reads in one place.
  function automatic logic tide_met(int unsigned occ, int unsigned mark);
    return occ >= mark;
  endfunction

  // Circular pointer advance for any depth, not only powers of two.
  function automatic int unsigned wrap_inc(int unsigned ptr, int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

  // Occupancy after one cycle of push and/or pop.
  function automatic int unsigned occ_next(int unsigned occ, logic push, logic pop);
    case ({push, pop})
      2'b10:   return occ + 1;
      2'b01:   return occ - 1;
      default: return occ;
    endcase
  endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int unsigned W     = 37,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wr_beat,
  input  logic             pop,
  output logic [W-1:0]     rd_beat,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(wrap_inc(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(wrap_inc(32'(rd_ptr), DEPTH));
      count <= CNT_W'(occ_next(32'(count), push, pop));
    end
  end

  assign rd_beat = mem[rd_ptr];
  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_occ_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> count == $past(count));
  assert_occ_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/wbuf_gate.sv
module wbuf_gate
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned MARK  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_last,
  input  logic             pop,
  input  logic             pop_last,
  input  logic [CNT_W-1:0] count,
  output logic             drain_en
);

  logic             open_q;
  logic [CNT_W-1:0] last_cnt;
  logic             tide_hit;
  logic             tail_held;
  logic             burst_done;

  assign tide_hit   = tide_met(32'(count), MARK);
  assign tail_held  = (last_cnt != '0);
  assign burst_done = pop && pop_last;
  assign drain_en   = open_q || tide_hit || tail_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      last_cnt <= '0;
    end else begin
      last_cnt <= CNT_W'(occ_next(32'(last_cnt), push && push_last, burst_done));
      if (burst_done)                open_q <= 1'b0;
      else if (tide_hit || tail_held) open_q <= 1'b1;
    end
  end

  assert_gate_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !open_q);
  assert_last_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_last) |=> drain_en);
  assert_tail_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_cnt <= count);

endmodule

// File: rtl/wbuf_tidemark.sv
module wbuf_tidemark
  import wbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned MARK   = 4,
  localparam int unsigned STRB_W = DATA_W / 8,
  localparam int unsigned BEAT_W = DATA_W + STRB_W + 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [STRB_W-1:0] s_strb,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [STRB_W-1:0] m_strb,
  output logic              m_last
);

  if (MARK < 1 || MARK > DEPTH) begin : g_bad_mark
    $error("fill mark must lie between 1 and DEPTH");
  end

  logic              push, pop, full, empty, drain_en;
  logic [CNT_W-1:0]  occ;
  logic [BEAT_W-1:0] in_beat, out_beat;

  assign in_beat = {s_data, s_strb, s_last};
  assign {m_data, m_strb, m_last} = out_beat;

  assign s_ready = !full;
  assign m_valid = !empty && drain_en;
  assign push    = s_valid && s_ready;
  assign pop     = m_valid && m_ready;

  wbuf_store #(.W(BEAT_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wr_beat(in_beat),
    .pop(pop), .rd_beat(out_beat),
    .count(occ), .full(full), .empty(empty)
  );

  wbuf_gate #(.DEPTH(DEPTH), .MARK(MARK)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_last(s_last),
    .pop(pop), .pop_last(m_last),
    .count(occ), .drain_en(drain_en)
  );

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable({m_data, m_strb, m_last})));
  assert_empty_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !m_valid);

endmodule

// File: tb/wbuf_tidemark_tb.sv
module wbuf_tidemark_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 32;
  localparam int SW    = DW / 8;
  localparam int DEPTH = 8;
  localparam int MARK  = 4;

  typedef struct packed {
    logic [DW-1:0] d;
    logic [SW-1:0] s;
    logic          l;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic [SW-1:0] s_strb = '0;
  logic s_ready, m_valid, m_last;
  logic [DW-1:0] m_data;
  logic [SW-1:0] m_strb;

  beat_t exp_q[$];
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wbuf_tidemark #(.DATA_W(DW), .DEPTH(DEPTH), .MARK(MARK)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_strb(s_strb), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_strb(m_strb), .m_last(m_last)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: a handshake seen at the negedge completes at the next posedge.
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      beat_t got, want;
      got = '{d: m_data, s: m_strb, l: m_last};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected output beat", longint'(got), 0);
      end else begin
        want = exp_q.pop_front();
        chk(got == want, "R7", "beat order/alignment", longint'(got), longint'(want));
      end
    end
  end

  // Driver: offer one beat, record it when accepted, return just after the storing edge.
  task automatic send(input logic [DW-1:0] d, input logic [SW-1:0] s, input logic l);
    s_data = d; s_strb = s; s_last = l; s_valid = 1'b1;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    exp_q.push_back('{d: d, s: s, l: l});
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(m_valid == 1'b0, "R1", "m_valid after reset", m_valid, 0);
    chk(s_ready == 1'b1, "R1", "s_ready after reset", s_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // R3 / R5: hold below the mark, open on the mark-th beat.
    m_ready = 1'b1;
    for (int i = 0; i < MARK - 1; i++) send(32'h100 + i, 4'hF, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(m_valid == 1'b0, "R3", "held below mark", m_valid, 0);
    end
    @(posedge clk); #1;
    send(32'h103, 4'h3, 1'b0);
    @(negedge clk);
    chk(m_valid == 1'b1, "R5", "open one cycle after mark beat", m_valid, 1);
    repeat (MARK) @(posedge clk);
    #1;
    @(negedge clk);
    chk(m_valid == 1'b0, "R6", "empty after drain", m_valid, 0);
    @(posedge clk); #1;
    // R6: gate still latched, a single non-last beat passes at once.
    send(32'h104, 4'h1, 1'b0);
    @(negedge clk);
    chk(m_valid == 1'b1, "R6", "latched open below mark", m_valid, 1);
    @(posedge clk); #1;
    send(32'h105, 4'h2, 1'b1);
    @(negedge clk);
    chk(m_last == 1'b1, "R6", "last beat offered", m_last, 1);
    @(posedge clk); #1;
    // R6: gate closed again after the last beat left.
    send(32'h200, 4'h8, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(m_valid == 1'b0, "R6", "closed for next burst", m_valid, 0);
    end
    @(posedge clk); #1;
    // R4: a last beat under the mark opens the output.
    send(32'h201, 4'h4, 1'b1);
    @(negedge clk);
    chk(m_valid == 1'b1, "R4", "last beat opens output", m_valid, 1);
    chk(m_last == 1'b0, "R4", "head is first beat", m_last, 0);
    drain();
    @(negedge clk);
    chk(m_valid == 1'b0, "R4", "empty after short burst", m_valid, 0);
    @(posedge clk); #1;

    // R2 / R8: fill completely behind a stalled consumer, then stream.
    m_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) send(32'h300 + i, SW'(i), 1'b0);
    s_data = 32'h308; s_strb = 4'h5; s_last = 1'b0; s_valid = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(s_ready == 1'b0, "R2", "full blocks input", s_ready, 0);
      chk(m_valid == 1'b1 && m_data == 32'h300, "R2", "stalled head held", m_data, 32'h300);
    end
    @(posedge clk); #1 m_ready = 1'b1;
    send(32'h308, 4'h5, 1'b0);
    for (int i = 9; i < 16; i++) begin
      s_data = 32'h300 + i; s_strb = SW'(i); s_last = (i == 15); s_valid = 1'b1;
      @(negedge clk);
      chk(s_ready == 1'b1 && m_valid == 1'b1, "R8", "steady push and pop",
          {s_ready, m_valid}, 2'b11);
      exp_q.push_back('{d: 32'h300 + i, s: SW'(i), l: (i == 15)});
      @(posedge clk); #1;
    end
    s_valid = 1'b0; s_last = 1'b0;
    drain();
    @(negedge clk);
    chk(m_valid == 1'b0, "R8", "stream fully drained", m_valid, 0);
    @(posedge clk); #1;

    // R9: reset mid-burst empties the buffer and closes the gate.
    m_ready = 1'b0;
    for (int i = 0; i < MARK; i++) send(32'h400 + i, 4'hA, 1'b0);
    @(negedge clk);
    chk(m_valid == 1'b1, "R9", "opened before reset", m_valid, 1);
    @(posedge clk); #1 rst_n = 1'b0;
    exp_q.delete();
    @(negedge clk);
    chk(m_valid == 1'b0 && s_ready == 1'b1, "R9", "reset state mid-burst",
        {m_valid, s_ready}, 2'b01);
    @(posedge clk); #1 rst_n = 1'b1;
    m_ready = 1'b1;
    for (int i = 0; i < MARK - 1; i++) send(32'h500 + i, 4'hC, 1'b0);
    @(negedge clk);
    chk(m_valid == 1'b0, "R9", "old beats and gate cleared", m_valid, 0);
    @(posedge clk); #1;
    send(32'h503, 4'hC, 1'b1);
    @(negedge clk);
    chk(m_valid == 1'b1, "R4", "post-reset burst released", m_valid, 1);
    drain();
    chk(exp_q.size() == 0, "R7", "all beats delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule